// File: doc/BRIEF.md
# Double-Word Integer Arithmetic Unit

This unit performs signed 32-bit integer arithmetic for a processor whose registers are 16 bits wide. Each result is returned as a high half and a low half (`resHi`, `resLo`). It also keeps two status flags: a carry/borrow flag `flagE` and an overflow flag `flagO`. For compare and skip operations it reports a small return offset, which the surrounding sequencer adds to its program counter.

Operation codes:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | subtract |
| 2 | reversed subtract |
| 3 | multiply |
| 4 | divide |
| 5 | reversed divide |
| 6 | negate |
| 7 | increment |
| 8 | decrement |
| 9 | three-way compare |
| 10 | increment with skip test |
| 11 | decrement with skip test |

Codes 12 to 15 are undefined.

A command is issued by pulsing `start` with the code and two operands, `srcX` (first) and `srcY` (second). The unit ignores `start` while `busy` is high.

- Single-cycle operations update the state on the accepting edge and raise `done` in the following cycle.
- Multiply and divide run a bit-serial engine over operand magnitudes. Each does one step per cycle and commits its result after `2*WORD_W` steps.

Top module: `dint_alu`

## Requirements
- R1: After reset, `resHi`, `resLo`, `flagE`, `flagO`, `retOffset`, `done` and `busy` are all zero.
- R2: Add (code 0) returns X+Y modulo 2^32. `flagE` becomes its old value ORed with (sum unsigned-less-than X). `flagO` is set exactly when X and Y share a sign and the sum's sign differs from it.
- R3: Subtract (code 1) returns X-Y. Reversed subtract (code 2) returns Y-X. `flagE` is ORed with (minuend unsigned-less-than subtrahend). `flagO` is set exactly when the operand signs differ and the result sign differs from the minuend sign.
- R4: Multiply (code 3) forms the signed product. If the product lies outside the signed 32-bit range, `flagO`=1 and the result is 0x7FFFFFFF. Otherwise `flagO`=0 and the result is the product. `flagE` is unchanged.
- R5: Divide (code 4, X/Y) and reversed divide (code 5, Y/X) return the signed quotient truncated toward zero with `flagO`=0. A zero divisor, or 0x80000000 divided by -1, gives 0x7FFFFFFF with `flagO`=1. `flagE` is unchanged.
- R6: Negate (code 6) returns -X. `flagO` is 1 exactly when X is 0x80000000. `flagE` is set when X is zero and is otherwise unchanged.
- R7: Increment (code 7) returns X+1. `flagO` is 1 exactly when the result is 0x80000000, and `flagE` is set when the result is zero. Decrement (code 8) returns X-1. `flagO` is 1 exactly when the result is 0x7FFFFFFF, and `flagE` is set when the result is 0xFFFFFFFF.
- R8: Compare (code 9) returns X unchanged and leaves both flags unchanged. `retOffset` is 0 when X equals Y, 1 when X is signed-less than Y, and 2 when X is signed-greater than Y. `retOffset` never takes the value 3.
- R9: The skip forms (codes 10 and 11) return X+1 and X-1 respectively. `retOffset` is 1 when that result is zero and 0 otherwise. Both flags are unchanged.
- R10: Undefined codes 12 to 15 leave `resHi`, `resLo` and both flags unchanged, and give `retOffset`=0.
- R11: `done` is a one-cycle pulse and is never high while `busy` is high. For single-cycle codes it rises in the cycle after `start` is accepted. For multiply and divide it rises `2*WORD_W+1` cycles after that. `start` is ignored while `busy` is high.
- R12: Every non-iterative operation other than compare, skip and undefined sets `retOffset` to 0. Multiply and divide also set `retOffset` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| opCode | input | 4 | Operation code |
| srcX | input | 2*WORD_W | First operand |
| srcY | input | 2*WORD_W | Second operand |
| busy | output | 1 | Iterative operation in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| resHi | output | WORD_W | High half of the result register |
| resLo | output | WORD_W | Low half of the result register |
| flagE | output | 1 | Carry/borrow flag |
| flagO | output | 1 | Overflow flag |
| retOffset | output | 2 | Return offset for compare and skip forms |

## Verification
The assertions assume that `opCode`, `srcX` and `srcY` hold known values whenever `start` is high and `busy` is low. They assume nothing about these inputs while the engine is running. The bench drives every input on the falling edge and holds operands steady across the accepting edge, so that condition always holds. The bench also pulses `start` deliberately in the middle of a multiply, to show that a command issued while busy is dropped rather than queued.

// File: rtl/dint_pkg.sv
package dint_pkg;
  localparam int DEF_WORD_W = 16;

  localparam logic [3:0] OP_ADD     = 4'd0;
  localparam logic [3:0] OP_SUB     = 4'd1;
  localparam logic [3:0] OP_SUBR    = 4'd2;
  localparam logic [3:0] OP_MUL     = 4'd3;
  localparam logic [3:0] OP_DIV     = 4'd4;
  localparam logic [3:0] OP_DIVR    = 4'd5;
  localparam logic [3:0] OP_NEG     = 4'd6;
  localparam logic [3:0] OP_INC     = 4'd7;
  localparam logic [3:0] OP_DEC     = 4'd8;
  localparam logic [3:0] OP_CMP     = 4'd9;
  localparam logic [3:0] OP_INCSKIP = 4'd10;
  localparam logic [3:0] OP_DECSKIP = 4'd11;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;
    logic stepIter;
    logic commitSimple;
    logic commitIter;
  } dintStrobe_t;

  function automatic logic isIterOp(input logic [3:0] op);
    return (op == OP_MUL) || (op == OP_DIV) || (op == OP_DIVR);
  endfunction

  function automatic logic isDivOp(input logic [3:0] op);
    return (op == OP_DIV) || (op == OP_DIVR);
  endfunction
endpackage

// File: rtl/dint_ctrl.sv
module dint_ctrl
  import dint_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  opCode,
  output logic        busy,
  output logic        doneOut,
  output dintStrobe_t strobes
);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} ctrlState_e;

  ctrlState_e state;
  logic [CNT_W-1:0] stepCnt;
  logic accept;

  assign accept = start && (state == S_IDLE);
  assign busy   = (state != S_IDLE);

  always_comb begin
    strobes = '0;
    if (accept) begin
      if (isIterOp(opCode)) strobes.loadOps = 1'b1;
      else                  strobes.commitSimple = 1'b1;
    end
    if (state == S_RUN) strobes.stepIter = 1'b1;
    if (state == S_FIN) strobes.commitIter = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strobes.commitSimple || strobes.commitIter;
      case (state)
        S_IDLE: begin
          stepCnt <= '0;
          if (accept && isIterOp(opCode)) state <= S_RUN;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dint_iter.sv
module dint_iter #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            load,
  input  logic            step,
  input  logic [DW-1:0]   magX,
  input  logic [DW-1:0]   magY,
  output logic [2*DW-1:0] prodMag,
  output logic [DW-1:0]   quoMag
);
  logic [2*DW-1:0] mulAcc, mulCand;
  logic [DW-1:0]   mulPlier;
  logic [DW-1:0]   divRem, divQuo, divDvs;
  logic [DW:0]     trial;
  logic            fits;

  // shift-add multiply step and restoring divide step, both one bit per cycle
  always_comb begin
    trial = {divRem, divQuo[DW-1]};
    fits  = (trial >= {1'b0, divDvs});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mulAcc   <= '0;
      mulCand  <= '0;
      mulPlier <= '0;
      divRem   <= '0;
      divQuo   <= '0;
      divDvs   <= '0;
    end else if (load) begin
      mulAcc   <= '0;
      mulCand  <= {{DW{1'b0}}, magX};
      mulPlier <= magY;
      divRem   <= '0;
      divQuo   <= magX;
      divDvs   <= magY;
    end else if (step) begin
      if (mulPlier[0]) mulAcc <= mulAcc + mulCand;
      mulCand  <= mulCand << 1;
      mulPlier <= mulPlier >> 1;
      divRem   <= fits ? DW'(trial - {1'b0, divDvs}) : trial[DW-1:0];
      divQuo   <= {divQuo[DW-2:0], fits};
    end
  end

  assign prodMag = mulAcc;
  assign quoMag  = divQuo;
endmodule

// File: rtl/dint_datapath.sv
module dint_datapath
  import dint_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  dintStrobe_t         strobes,
  input  logic [3:0]          opCode,
  input  logic [2*WORD_W-1:0] srcX,
  input  logic [2*WORD_W-1:0] srcY,
  output logic [2*WORD_W-1:0] resWord,
  output logic                flagE,
  output logic                flagO,
  output logic [1:0]          retOffset
);
  localparam int DW = 2 * WORD_W;
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = ~MIN_NEG;
  localparam logic [DW-1:0] ALL_ONE = '1;
  localparam logic [2*DW-1:0] LIM_NEG = {{DW{1'b0}}, MIN_NEG};
  localparam logic [2*DW-1:0] LIM_POS = {{DW{1'b0}}, MAX_POS};

  // single-cycle path
  logic [DW-1:0] sum, subA, subB, diff, incV, decV, negV;
  logic [DW-1:0] nRes;
  logic          wrRes, nE, nO;
  logic [1:0]    nOff;

  always_comb begin
    sum  = srcX + srcY;
    subA = (opCode == OP_SUBR) ? srcY : srcX;
    subB = (opCode == OP_SUBR) ? srcX : srcY;
    diff = subA - subB;
    incV = srcX + 1'b1;
    decV = srcX - 1'b1;
    negV = ~srcX + 1'b1;
    nRes  = resWord;
    wrRes = 1'b1;
    nE    = flagE;
    nO    = flagO;
    nOff  = 2'd0;
    case (opCode)
      OP_ADD: begin
        nRes = sum;
        nE   = flagE | (sum < srcX);
        nO   = ~(srcX[DW-1] ^ srcY[DW-1]) & (srcX[DW-1] ^ sum[DW-1]);
      end
      OP_SUB, OP_SUBR: begin
        nRes = diff;
        nE   = flagE | (subA < subB);
        nO   = (subA[DW-1] ^ subB[DW-1]) & (subA[DW-1] ^ diff[DW-1]);
      end
      OP_NEG: begin
        nRes = negV;
        nO   = (srcX == MIN_NEG);
        nE   = flagE | (srcX == '0);
      end
      OP_INC: begin
        nRes = incV;
        nO   = (incV == MIN_NEG);
        nE   = flagE | (incV == '0);
      end
      OP_DEC: begin
        nRes = decV;
        nO   = (decV == MAX_POS);
        nE   = flagE | (decV == ALL_ONE);
      end
      OP_CMP: begin
        nRes = srcX;
        if ($signed(srcX) < $signed(srcY))      nOff = 2'd1;
        else if ($signed(srcX) > $signed(srcY)) nOff = 2'd2;
      end
      OP_INCSKIP: begin
        nRes = incV;
        nOff = (incV == '0) ? 2'd1 : 2'd0;
      end
      OP_DECSKIP: begin
        nRes = decV;
        nOff = (decV == '0) ? 2'd1 : 2'd0;
      end
      default: wrRes = 1'b0;
    endcase
  end

  // iterative path: operands swapped for the reversed divide, magnitudes to engine
  logic [DW-1:0] itX, itY, magX, magY, quoMag;
  logic [2*DW-1:0] prodMag;
  logic iterDiv, iterNeg, iterDivOvf;
  logic [DW-1:0] iterRes;
  logic iterOvf;

  always_comb begin
    itX  = (opCode == OP_DIVR) ? srcY : srcX;
    itY  = (opCode == OP_DIVR) ? srcX : srcY;
    magX = itX[DW-1] ? (~itX + 1'b1) : itX;
    magY = itY[DW-1] ? (~itY + 1'b1) : itY;
  end

  dint_iter #(.DW(DW)) uIter (
    .clk     (clk),
    .rstN    (rstN),
    .load    (strobes.loadOps),
    .step    (strobes.stepIter),
    .magX    (magX),
    .magY    (magY),
    .prodMag (prodMag),
    .quoMag  (quoMag)
  );

  always_comb begin
    if (iterDiv) begin
      iterOvf = iterDivOvf;
      iterRes = iterNeg ? (~quoMag + 1'b1) : quoMag;
    end else begin
      iterOvf = iterNeg ? (prodMag > LIM_NEG) : (prodMag > LIM_POS);
      iterRes = iterNeg ? (~prodMag[DW-1:0] + 1'b1) : prodMag[DW-1:0];
    end
    if (iterOvf) iterRes = MAX_POS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resWord    <= '0;
      flagE      <= 1'b0;
      flagO      <= 1'b0;
      retOffset  <= 2'd0;
      iterDiv    <= 1'b0;
      iterNeg    <= 1'b0;
      iterDivOvf <= 1'b0;
    end else begin
      if (strobes.loadOps) begin
        iterDiv    <= isDivOp(opCode);
        iterNeg    <= itX[DW-1] ^ itY[DW-1];
        iterDivOvf <= (itY == '0) || ((itX == MIN_NEG) && (itY == ALL_ONE));
      end
      if (strobes.commitSimple) begin
        if (wrRes) resWord <= nRes;
        flagE     <= nE;
        flagO     <= nO;
        retOffset <= nOff;
      end
      if (strobes.commitIter) begin
        resWord   <= iterRes;
        flagO     <= iterOvf;
        retOffset <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/dint_alu.sv
module dint_alu
  import dint_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [3:0]          opCode,
  input  logic [2*WORD_W-1:0] srcX,
  input  logic [2*WORD_W-1:0] srcY,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   resHi,
  output logic [WORD_W-1:0]   resLo,
  output logic                flagE,
  output logic                flagO,
  output logic [1:0]          retOffset
);
  localparam int DW = 2 * WORD_W;

  dintStrobe_t   strobes;
  logic [DW-1:0] resWord;

  dint_ctrl #(.STEPS(DW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opCode  (opCode),
    .busy    (busy),
    .doneOut (done),
    .strobes (strobes)
  );

  dint_datapath #(.WORD_W(WORD_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opCode    (opCode),
    .srcX      (srcX),
    .srcY      (srcY),
    .resWord   (resWord),
    .flagE     (flagE),
    .flagO     (flagO),
    .retOffset (retOffset)
  );

  assign resHi = resWord[DW-1:WORD_W];
  assign resLo = resWord[WORD_W-1:0];
endmodule

// File: rtl/dint_alu_chk.sv
module dint_alu_chk
  import dint_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [3:0]          opCode,
  input logic [2*WORD_W-1:0] srcX,
  input logic [2*WORD_W-1:0] srcY,
  input logic                busy,
  input logic                done,
  input logic [WORD_W-1:0]   resHi,
  input logic [WORD_W-1:0]   resLo,
  input logic                flagE,
  input logic                flagO,
  input logic [1:0]          retOffset
);
  localparam int DW = 2 * WORD_W;
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  logic accepted;
  logic lastIter;
  assign accepted = start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) lastIter <= 1'b0;
    else if (accepted) lastIter <= isIterOp(opCode);
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !accepted) |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_offset_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    retOffset != 2'd3);

  assert_undef_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opCode >= 4'd12) |=> ($stable({resHi, resLo}) && $stable(flagE) && $stable(flagO)));

  // covers R4 and R5: saturated value on overflow
  assert_sat_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastIter && flagO) |-> ({resHi, resLo} == MAX_POS));

  assert_e_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opCode == OP_ADD) |=> (flagE || !$past(flagE)));

  assert_cmp_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && opCode == OP_CMP) |=> ({resHi, resLo} == $past(srcX)));
endmodule

bind dint_alu dint_alu_chk #(.WORD_W(WORD_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .opCode    (opCode),
  .srcX      (srcX),
  .srcY      (srcY),
  .busy      (busy),
  .done      (done),
  .resHi     (resHi),
  .resLo     (resLo),
  .flagE     (flagE),
  .flagO     (flagO),
  .retOffset (retOffset)
);

// File: tb/tb_dint_alu.sv
module tb_dint_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int DW = 32;
  localparam int ITER_LAT = DW + 1;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] x;
    logic [31:0] y;
    logic [31:0] res;
    logic        e;
    logic        o;
    logic [1:0]  off;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0, 1'b0, 2'd0},
    '{4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 2'd0},
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 2'd0},
    '{4'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b1, 1'b0, 2'd0},
    '{4'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 2'd0},
    '{4'd2, 32'h00000007, 32'h00000005, 32'hFFFFFFFE, 1'b1, 1'b0, 2'd0},
    '{4'd3, 32'h00000003, 32'hFFFFFFFC, 32'hFFFFFFF4, 1'b0, 1'b0, 2'd0},
    '{4'd3, 32'h00010000, 32'h00010000, 32'h7FFFFFFF, 1'b0, 1'b1, 2'd0},
    '{4'd3, 32'h80000000, 32'h00000001, 32'h80000000, 1'b0, 1'b0, 2'd0},
    '{4'd3, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 2'd0},
    '{4'd3, 32'hFFFF8000, 32'h00010000, 32'h80000000, 1'b0, 1'b0, 2'd0},
    '{4'd4, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD, 1'b0, 1'b0, 2'd0},
    '{4'd4, 32'h00000005, 32'h00000000, 32'h7FFFFFFF, 1'b0, 1'b1, 2'd0},
    '{4'd4, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 2'd0},
    '{4'd5, 32'h00000002, 32'h00000064, 32'h00000032, 1'b0, 1'b0, 2'd0},
    '{4'd4, 32'h00000007, 32'hFFFFFFF9, 32'hFFFFFFFF, 1'b0, 1'b0, 2'd0},
    '{4'd6, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 2'd0},
    '{4'd6, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 1'b1, 2'd0},
    '{4'd6, 32'h00000005, 32'h00000000, 32'hFFFFFFFB, 1'b0, 1'b0, 2'd0},
    '{4'd7, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 2'd0},
    '{4'd7, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 1'b0, 1'b1, 2'd0},
    '{4'd8, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 2'd0},
    '{4'd8, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 1'b0, 1'b1, 2'd0},
    '{4'd9, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0, 2'd1},
    '{4'd9, 32'h00000005, 32'h00000005, 32'h00000005, 1'b0, 1'b0, 2'd0},
    '{4'd9, 32'h00000007, 32'hFFFFFFFD, 32'h00000007, 1'b0, 1'b0, 2'd2},
    '{4'd10, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 2'd1},
    '{4'd10, 32'h00000004, 32'h00000000, 32'h00000005, 1'b0, 1'b0, 2'd0},
    '{4'd11, 32'h00000001, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 2'd1},
    '{4'd11, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] opCode = '0;
  logic [DW-1:0] srcX = '0;
  logic [DW-1:0] srcY = '0;
  logic busy, done, flagE, flagO;
  logic [WORD_W-1:0] resHi, resLo;
  logic [1:0] retOffset;

  int testsRun = 0;
  int testsFailed = 0;
  int lastLatency = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dint_alu #(.WORD_W(WORD_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .srcX(srcX), .srcY(srcY), .busy(busy), .done(done),
    .resHi(resHi), .resLo(resLo), .flagE(flagE), .flagO(flagO),
    .retOffset(retOffset)
  );

  function automatic string reqTag(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      4'd10, 4'd11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // issue one command, wait for done, leave the time at the negedge where done is seen
  task automatic runOp(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y);
    int cnt;
    @(negedge clk);
    opCode = op;
    srcX = x;
    srcY = y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    lastLatency = cnt;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R11 done never seen: actual 0 expected 1");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    checkVal("R1", "result", {resHi, resLo}, 32'h0);
    checkVal("R1", "flags/done/busy", {28'h0, flagE, flagO, done, busy}, 32'h0);
    checkVal("R1", "offset", {30'h0, retOffset}, 32'h0);

    // vector table, each from a fresh reset
    for (int i = 0; i < NV; i++) begin
      doReset();
      runOp(VECS[i].op, VECS[i].x, VECS[i].y);
      checkVal(reqTag(VECS[i].op), "result", {resHi, resLo}, VECS[i].res);
      checkVal(reqTag(VECS[i].op), "flagE", {31'h0, flagE}, {31'h0, VECS[i].e});
      checkVal(reqTag(VECS[i].op), "flagO", {31'h0, flagO}, {31'h0, VECS[i].o});
      checkVal(reqTag(VECS[i].op), "retOffset", {30'h0, retOffset}, {30'h0, VECS[i].off});
    end

    // R11: latencies and single-cycle done pulse
    doReset();
    runOp(4'd0, 32'h1, 32'h1);
    checkVal("R11", "simple latency", lastLatency, 0);
    @(negedge clk);
    checkVal("R11", "done pulse width", {31'h0, done}, 32'h0);
    runOp(4'd3, 32'h7, 32'h6);
    checkVal("R11", "iterative latency", lastLatency, ITER_LAT);
    checkVal("R4", "7*6", {resHi, resLo}, 32'd42);

    // R2 / R12: sticky carry and flag retention
    doReset();
    runOp(4'd0, 32'hFFFFFFFF, 32'h2);
    runOp(4'd0, 32'h1, 32'h1);
    checkVal("R2", "E sticky after no-carry add", {31'h0, flagE}, 32'h1);
    runOp(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    runOp(4'd9, 32'h3, 32'h3);
    checkVal("R8", "compare keeps O", {31'h0, flagO}, 32'h1);
    checkVal("R8", "compare keeps E", {31'h0, flagE}, 32'h1);
    runOp(4'd4, 32'h9, 32'h3);
    checkVal("R5", "divide keeps E", {31'h0, flagE}, 32'h1);
    checkVal("R5", "divide clears O", {31'h0, flagO}, 32'h0);
    runOp(4'd11, 32'h1, 32'h0);
    checkVal("R9", "skip keeps E", {31'h0, flagE}, 32'h1);
    runOp(4'd1, 32'h9, 32'h2);
    checkVal("R12", "offset cleared after skip", {30'h0, retOffset}, 32'h0);

    // R10: undefined codes keep result and flags
    doReset();
    runOp(4'd0, 32'h7FFFFFFF, 32'h1);
    for (int c = 12; c < 16; c++) begin
      runOp(4'(c), 32'h12345678, 32'h9ABCDEF0);
      checkVal("R10", "result held", {resHi, resLo}, 32'h80000000);
      checkVal("R10", "flags held", {30'h0, flagE, flagO}, 32'h1);
      checkVal("R10", "offset zero", {30'h0, retOffset}, 32'h0);
    end

    // R11: start while busy is ignored
    doReset();
    @(negedge clk);
    opCode = 4'd3; srcX = 32'h3; srcY = 32'h5; start = 1'b1;
    @(negedge clk);
    opCode = 4'd0; srcX = 32'h1; srcY = 32'h1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    begin
      int cnt = 0;
      while (!done && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
    end
    checkVal("R11", "busy start ignored", {resHi, resLo}, 32'd15);
    begin
      int extra = 0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      checkVal("R11", "no extra done", extra, 0);
    end
    checkVal("R11", "result after idle", {resHi, resLo}, 32'd15);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule